// File: doc/BRIEF.md
# Register-Pair Bit-Field Extractor

This block pulls a bit field out of a 64-bit value formed by joining two 32-bit extension registers. The first register holds the upper word and the second the lower word. The field start is measured from the most significant bit of the pair. The field is zero-extended and sent back as write-back data for the upper-word register. The field length comes either from a 5-bit immediate in the instruction or from the low bits of a general-purpose register value. A two-bit sub-opcode selects which source is used.

The surrounding pipeline decodes the instruction and supplies the operand values: both pair words, the offset register value and the width register value. The block returns a write-back strobe, the destination index and the data, all registered one clock after the request. Register storage and decoding of other instruction groups belong to the surrounding pipeline.

Top module: `pairfield_extract`

## Requirements
- R1: While reset is held and right after it is released, `wb_valid` is 0 and `wb_data` is 0.
- R2: `insn[15:14]` = 2'b10 selects the immediate form. The field width w is `insn[20:16]`.
- R3: `insn[15:14]` = 2'b11 selects the register form. w is `wid_val[4:0]`, and bits 31..5 of `wid_val` have no effect on the result.
- R4: A request with `insn[15:14]` = 2'b00 or 2'b01 produces no write-back: `wb_valid` is 0 in the following cycle.
- R5: The offset o is `off_val[4:0]`, and bits 31..5 of `off_val` have no effect. The result is `({hi_val,lo_val} >> (64 - o - w))` with every bit at position w and above forced to 0.
- R6: When o + w <= 32, the field comes only from `hi_val`, and `lo_val` has no effect on the result.
- R7: When o + w > 32, the field spans both words. Its low (o + w - 32) bits come from the top bits of `lo_val`.
- R8: A width of 0 gives `wb_data` = 0 with `wb_valid` still 1.
- R9: An accepted request sampled at a rising edge raises `wb_valid` after that edge. In the same cycle, `wb_index` equals the upper-word index `insn[9:6]`.
- R10: A cycle with `in_valid` low gives `wb_valid` = 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| insn | input | 32 | Instruction word: [15:14] sub-opcode, [9:6] upper-word index, [13:10] lower-word index, [20:16] immediate width or width register index, [25:21] offset register index |
| hi_val | input | 32 | Upper word of the pair (register at insn[9:6]) |
| lo_val | input | 32 | Lower word of the pair (register at insn[13:10]) |
| off_val | input | 32 | Value of the offset register |
| wid_val | input | 32 | Value of the width register (register form only) |
| wb_valid | output | 1 | Write-back strobe |
| wb_index | output | 4 | Destination register index |
| wb_data | output | 32 | Zero-extended extracted field |

## Verification
Every result appears exactly one rising edge after its request is sampled, and an idle or non-extract cycle shows as a low strobe one edge later. The driver applies a request on a falling edge and queues the expected strobe, index and data in the same cycle. The monitor pops one queue entry one nanosecond after each following rising edge, so each comparison falls in the single cycle where that result is due. Expected fields come from a bit-by-bit walk over the 64-bit pair, which is a different method from the shifter used in the design.

// File: rtl/pairfield_extract.sv
module pairfield_extract #(
  parameter int XLEN = 32,
  parameter int IDXW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [31:0]     insn,
  input  logic [XLEN-1:0] hi_val,
  input  logic [XLEN-1:0] lo_val,
  input  logic [XLEN-1:0] off_val,
  input  logic [XLEN-1:0] wid_val,
  output logic            wb_valid,
  output logic [IDXW-1:0] wb_index,
  output logic [XLEN-1:0] wb_data
);
  localparam int SHW   = $clog2(XLEN);
  localparam int PAIRW = 2 * XLEN;
  localparam int AMTW  = SHW + 2;
  localparam int HI_POS  = 6;
  localparam int WID_POS = 16;

  logic            is_extract;
  logic            reg_width;
  logic [SHW-1:0]  offs;
  logic [SHW-1:0]  wid;
  logic [AMTW-1:0] shamt;
  logic [PAIRW-1:0] shifted;
  logic [XLEN-1:0] keep_mask;
  logic [XLEN-1:0] field;

  assign is_extract = insn[15];
  assign reg_width  = insn[14];
  assign offs       = off_val[SHW-1:0];
  assign wid        = reg_width ? wid_val[SHW-1:0] : insn[WID_POS +: SHW];
  assign shamt      = AMTW'(PAIRW) - {2'b00, offs} - {2'b00, wid};
  assign shifted    = {hi_val, lo_val} >> shamt;
  assign keep_mask  = ~({XLEN{1'b1}} << wid);
  assign field      = shifted[XLEN-1:0] & keep_mask;

  wire unused_bits = ^{insn[31:WID_POS+SHW], insn[HI_POS+2*IDXW-1:HI_POS+IDXW],
                       insn[HI_POS-1:0], off_val[XLEN-1:SHW], wid_val[XLEN-1:SHW]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_valid <= 1'b0;
      wb_index <= '0;
      wb_data  <= '0;
    end else begin
      wb_valid <= in_valid & is_extract;
      if (in_valid & is_extract) begin
        wb_index <= insn[HI_POS +: IDXW];
        wb_data  <= field;
      end
    end
  end
endmodule

// File: rtl/pairfield_extract_chk.sv
module pairfield_extract_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] insn,
  input logic        wb_valid,
  input logic [3:0]  wb_index,
  input logic [31:0] wb_data
);
  p_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && insn[15]) |=> wb_valid);

  p_index_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && insn[15]) |=> (wb_index == $past(insn[9:6])));

  p_no_wb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !insn[15]) |=> !wb_valid);

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !wb_valid);

  p_zero_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && insn[15:14] == 2'b10 && insn[20:16] == 5'd0) |=> (wb_data == 32'd0));

  p_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && insn[15:14] == 2'b10) |=> ((wb_data >> $past(insn[20:16])) == 32'd0));
endmodule

bind pairfield_extract pairfield_extract_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
  .wb_valid(wb_valid), .wb_index(wb_index), .wb_data(wb_data)
);

// File: tb/sim_pairfield_extract.sv
`timescale 1ns/100ps
module sim_pairfield_extract;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] insn = '0;
  logic [31:0] hi_val = '0, lo_val = '0, off_val = '0, wid_val = '0;
  logic        wb_valid;
  logic [3:0]  wb_index;
  logic [31:0] wb_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [36:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  pairfield_extract u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
    .hi_val(hi_val), .lo_val(lo_val), .off_val(off_val), .wid_val(wid_val),
    .wb_valid(wb_valid), .wb_index(wb_index), .wb_data(wb_data)
  );

  function automatic logic [31:0] make_insn(input logic [1:0] sub, input logic [3:0] hi_i,
                                            input logic [3:0] lo_i, input logic [4:0] f_w,
                                            input logic [4:0] f_o);
    return {6'b100110, f_o, f_w, sub, lo_i, hi_i, 6'b011100};
  endfunction

  function automatic logic [31:0] ref_field(input logic [31:0] h, input logic [31:0] l,
                                            input int o, input int w);
    logic [63:0] pair;
    logic [31:0] r;
    pair = {h, l};
    r = '0;
    for (int i = 0; i < w; i++) r[i] = pair[63 - o - (w - 1 - i)];
    return r;
  endfunction

  task automatic step(input logic v, input logic [31:0] ins, input logic [31:0] h,
                      input logic [31:0] l, input logic [31:0] ov, input logic [31:0] wv,
                      input string tag);
    logic ev;
    int w;
    @(negedge clk);
    in_valid = v; insn = ins; hi_val = h; lo_val = l; off_val = ov; wid_val = wv;
    ev = v & ins[15];
    w = ins[14] ? int'(wv[4:0]) : int'(ins[20:16]);
    exp_q.push_back({ev, ins[9:6], ev ? ref_field(h, l, int'(ov[4:0]), w) : 32'd0});
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && exp_q.size() > 0) begin
      logic [36:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (wb_valid !== e[36]) begin
        errors++;
        $display("FAIL %s wb_valid actual %0b expected %0b", t, wb_valid, e[36]);
      end else if (e[36]) begin
        checks++;
        if (wb_index !== e[35:32] || wb_data !== e[31:0]) begin
          errors++;
          $display("FAIL %s index/data actual %0d/%08h expected %0d/%08h",
                   t, wb_index, wb_data, e[35:32], e[31:0]);
        end
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b;
    in_valid = 1'b1;
    insn = make_insn(2'b10, 4'd3, 4'd4, 5'd8, 5'd1);
    hi_val = 32'hFFFF_FFFF;
    repeat (4) @(posedge clk);
    #1;
    checks++;
    if (wb_valid !== 1'b0 || wb_data !== 32'd0) begin
      errors++;
      $display("FAIL R1 reset actual %0b/%08h expected 0/00000000", wb_valid, wb_data);
    end
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b1;

    a = 32'hDEAD_BEEF; b = 32'h1234_5678;
    // R2 R5 R6: immediate form, field in the upper word
    step(1, make_insn(2'b10, 4'd1, 4'd2, 5'd1, 5'd0), a, b, 32'd0, 0, "R2 o0 w1");
    step(1, make_insn(2'b10, 4'd2, 4'd3, 5'd31, 5'd0), a, b, 32'd0, 0, "R6 o0 w31");
    step(1, make_insn(2'b10, 4'd5, 4'd3, 5'd1, 5'd0), a, b, 32'd31, 0, "R6 o31 w1");
    step(1, make_insn(2'b10, 4'd6, 4'd3, 5'd16, 5'd0), a, 32'hFFFF_FFFF, 32'd8, 0, "R6 lo ignored");
    // R7: spanning
    step(1, make_insn(2'b10, 4'd7, 4'd3, 5'd31, 5'd0), a, b, 32'd31, 0, "R7 o31 w31");
    step(1, make_insn(2'b10, 4'd8, 4'd3, 5'd20, 5'd0), a, b, 32'd20, 0, "R7 o20 w20");
    step(1, make_insn(2'b10, 4'd9, 4'd3, 5'd2, 5'd0), 32'h0, 32'hC000_0000, 32'd31, 0, "R7 boundary");
    // R8
    step(1, make_insn(2'b10, 4'd10, 4'd3, 5'd0, 5'd0), a, b, 32'd7, 0, "R8 imm w0");
    step(1, make_insn(2'b11, 4'd11, 4'd3, 5'd4, 5'd0), a, b, 32'd7, 32'h0000_0020, "R8 reg w0");
    // R3: register width, upper bits ignored
    step(1, make_insn(2'b11, 4'd12, 4'd3, 5'd4, 5'd0), a, b, 32'd12, 32'hFFFF_FF0C, "R3 reg w12");
    step(1, make_insn(2'b11, 4'd13, 4'd3, 5'd0, 5'd0), a, b, 32'd30, 32'h8000_001F, "R3 reg span");
    // R5: upper offset bits ignored
    step(1, make_insn(2'b10, 4'd14, 4'd3, 5'd9, 5'd0), a, b, 32'hFFFF_FFE5, 0, "R5 offset high bits");
    // R4 and R10
    step(1, make_insn(2'b00, 4'd15, 4'd3, 5'd9, 5'd0), a, b, 32'd5, 0, "R4 sub 00");
    step(1, make_insn(2'b01, 4'd15, 4'd3, 5'd9, 5'd0), a, b, 32'd5, 0, "R4 sub 01");
    step(0, make_insn(2'b10, 4'd15, 4'd3, 5'd9, 5'd0), a, b, 32'd5, 0, "R10 idle");
    // R9: back-to-back with varying index
    for (int i = 0; i < 16; i++)
      step(1, make_insn(2'b10, 4'(i), 4'd0, 5'(i + 3), 5'd0), a ^ 32'(i), b, 32'(i * 2), 0, "R9 burst");
    for (int i = 0; i < 300; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] | r[1], make_insn(r[3:2], r[7:4], r[11:8], r[16:12], 5'd0),
           $urandom, $urandom, $urandom, $urandom, "R5 random");
    end
    step(0, '0, '0, '0, '0, '0, "R10 drain");
    repeat (4) @(posedge clk);
    #2;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule